// File: doc/BRIEF.md
# Duplex Host/Coprocessor Mailbox

This block sits between a host CPU and a coprocessor. It carries one 31-bit message at a time in each direction. The host sees four 16-bit registers, grouped as two pairs. Each pair has a high halfword and a low halfword.

The top bit of each high halfword is a "full" flag. The other fifteen bits of the high halfword are the upper part of the message, and the low halfword is the lower part. Registers are big-endian, so the high halfword sits at the lower offset.

**Host to coprocessor.** The host writes the low halfword first, then the high halfword. The high write sets the full flag, so the whole 31-bit message reaches the coprocessor in the same cycle as the flag. The coprocessor then pulses a take strobe, which empties the slot.

**Coprocessor to host.** The coprocessor posts a message with a single-cycle strobe. A post is accepted only while the slot is empty. The host reads the high halfword, then the low halfword. The read of the low halfword empties the slot, and the slot may then take the next post.

Top module: `mbx_duplex`

## Requirements
- R1: After a synchronous active-low reset, all four registers read 0, `cp_in_valid` is 0 and `cp_out_ready` is 1.
- R2: A host write to offset 0x2 stores the low inbound halfword. The stored value reads back at offset 0x2. The write leaves `cp_in_valid` unchanged.
- R3: A host write to offset 0x0 stores the high inbound halfword. From the next cycle, `cp_in_valid` equals bit 15 of the written value, and `cp_in_data` equals {written bits 14..0, stored low halfword}.
- R4: A `cp_in_take` pulse clears the inbound flag. After it, offset 0x0 reads with bit 15 at 0 and bits 14..0 unchanged, and `cp_in_data` is unchanged. A pulse while the flag is already clear has no effect.
- R5: If a host write to offset 0x0 and a `cp_in_take` pulse fall in the same cycle, the write wins. The flag and the data take the written value.
- R6: A `cp_out_post` pulse while `cp_out_ready` is 1 stores `cp_out_post_data` and sets the outbound flag, and `cp_out_ready` drops the next cycle. After that, offset 0x4 reads {1, data bits 30..16} and offset 0x6 reads data bits 15..0.
- R7: A `cp_out_post` pulse while the outbound flag is set is ignored. The stored message and the flag are unchanged. This also holds in the cycle in which the host reads offset 0x6.
- R8: A host read of offset 0x6 clears the outbound flag, so `cp_out_ready` returns to 1 and offset 0x4 shows bit 15 at 0. A read of offset 0x4 leaves the flag set.
- R9: Host writes to offsets 0x4 and 0x6 are ignored. The outbound contents and the flag are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_addr | input | 3 | Byte offset; bits 2..1 select the register |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for `host_addr`, combinational |
| cp_in_valid | output | 1 | Inbound message present |
| cp_in_data | output | 31 | Inbound message payload |
| cp_in_take | input | 1 | Coprocessor has consumed the inbound message |
| cp_out_post | input | 1 | Coprocessor posts an outbound message |
| cp_out_post_data | input | 31 | Payload of the posted message |
| cp_out_ready | output | 1 | Outbound slot empty; a post will be accepted |

## Verification
Two pairs of events can land in the same cycle.

- **Inbound:** a host write of the high halfword and a coprocessor take. The bench fills the slot, then drives both strobes on one edge. It then checks that the flag stays set and that the payload carries the new value.
- **Outbound:** a post and the host read that empties the slot. The bench fills the slot, then drives both on one edge. It then checks three things: the read returned the old message, the slot ends empty, and the old upper data is still in place. Together these show the late post was dropped.

// File: rtl/mbx_pkg.sv
// Package: shared register-slot encoding for the duplex mailbox.
// Assumes: register index is byte offset bits 2..1 (halfword aligned).
package mbx_pkg;
    typedef enum logic [1:0] {
        SLOT_IN_HI  = 2'd0,
        SLOT_IN_LO  = 2'd1,
        SLOT_OUT_HI = 2'd2,
        SLOT_OUT_LO = 2'd3
    } slot_e;
endpackage

// File: rtl/mbx_decode.sv
// Module: mbx_decode
// Turns host strobes and offset into per-register enables.
// Assumes: one bus operation per cycle; offset bit 0 is ignored.
module mbx_decode
    import mbx_pkg::*;
(
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [2:0] host_addr,
    output slot_e      slot,
    output logic       wr_in_hi,
    output logic       wr_in_lo,
    output logic       rd_out_lo
);
    // Decode the halfword slot and the enables that act on state.
    always_comb begin
        slot      = slot_e'(host_addr[2:1]);
        wr_in_hi  = host_wr && (slot == SLOT_IN_HI);
        wr_in_lo  = host_wr && (slot == SLOT_IN_LO);
        rd_out_lo = host_rd && (slot == SLOT_OUT_LO);
    end
endmodule

// File: rtl/mbx_inbound.sv
// Module: mbx_inbound
// Host-to-coprocessor slot. Holds both halfwords; the flag is bit HALF_W-1
// of the high half. A high write beats a same-cycle take.
// Assumes: host writes the low half before the high half.
module mbx_inbound #(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [HALF_W-1:0] wdata,
    input  logic              take,
    output logic [HALF_W-1:0] hi_q,
    output logic [HALF_W-1:0] lo_q
);
    localparam int FLAG = HALF_W - 1;

    // Low halfword register: host writes only.
    always_ff @(posedge clk) begin
        if (!rst_n)     lo_q <= '0;
        else if (wr_lo) lo_q <= wdata;
    end

    // High halfword register: host write wins, else take clears the flag.
    always_ff @(posedge clk) begin
        if (!rst_n)      hi_q <= '0;
        else if (wr_hi)  hi_q <= wdata;
        else if (take)   hi_q[FLAG] <= 1'b0;
    end
endmodule

// File: rtl/mbx_outbound.sv
// Module: mbx_outbound
// Coprocessor-to-host slot. A post is taken only while the slot is empty;
// a host read of the low half empties it.
// Assumes: post is a one-cycle strobe gated by the ready output.
module mbx_outbound #(
    parameter int HALF_W = 16,
    localparam int PAY_W = 2 * HALF_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             post,
    input  logic [PAY_W-1:0] post_data,
    input  logic             rd_lo,
    output logic             full,
    output logic [PAY_W-1:0] data_q
);
    logic accept;

    // A post is accepted only into an empty slot.
    always_comb accept = post && !full;

    // Payload register: loads on an accepted post.
    always_ff @(posedge clk) begin
        if (!rst_n)      data_q <= '0;
        else if (accept) data_q <= post_data;
    end

    // Full flag: set by an accepted post, cleared by a low-half read.
    always_ff @(posedge clk) begin
        if (!rst_n)      full <= 1'b0;
        else if (accept) full <= 1'b1;
        else if (rd_lo)  full <= 1'b0;
    end
endmodule

// File: rtl/mbx_duplex.sv
// Module: mbx_duplex (top)
// Two 31-bit mailboxes behind four big-endian halfword registers.
// Assumes: single-cycle host strobes; outbound offsets are read-only.
module mbx_duplex
    import mbx_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int PAY_W = 2 * HALF_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [2:0]        host_addr,
    input  logic [HALF_W-1:0] host_wdata,
    output logic [HALF_W-1:0] host_rdata,
    output logic              cp_in_valid,
    output logic [PAY_W-1:0]  cp_in_data,
    input  logic              cp_in_take,
    input  logic              cp_out_post,
    input  logic [PAY_W-1:0]  cp_out_post_data,
    output logic              cp_out_ready
);
    slot_e             slot;
    logic              wr_in_hi, wr_in_lo, rd_out_lo;
    logic [HALF_W-1:0] in_hi, in_lo;
    logic              out_full;
    logic [PAY_W-1:0]  out_data;

    mbx_decode dec_i (
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .host_addr (host_addr),
        .slot      (slot),
        .wr_in_hi  (wr_in_hi),
        .wr_in_lo  (wr_in_lo),
        .rd_out_lo (rd_out_lo)
    );

    mbx_inbound #(.HALF_W(HALF_W)) in_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_hi (wr_in_hi),
        .wr_lo (wr_in_lo),
        .wdata (host_wdata),
        .take  (cp_in_take),
        .hi_q  (in_hi),
        .lo_q  (in_lo)
    );

    mbx_outbound #(.HALF_W(HALF_W)) out_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .post      (cp_out_post),
        .post_data (cp_out_post_data),
        .rd_lo     (rd_out_lo),
        .full      (out_full),
        .data_q    (out_data)
    );

    // Coprocessor-side view of both slots.
    always_comb begin
        cp_in_valid  = in_hi[HALF_W-1];
        cp_in_data   = {in_hi[HALF_W-2:0], in_lo};
        cp_out_ready = !out_full;
    end

    // Host read multiplexer over the four halfword registers.
    always_comb begin
        unique case (slot)
            SLOT_IN_HI:  host_rdata = in_hi;
            SLOT_IN_LO:  host_rdata = in_lo;
            SLOT_OUT_HI: host_rdata = {out_full, out_data[PAY_W-1:HALF_W]};
            default:     host_rdata = out_data[HALF_W-1:0];
        endcase
    end
endmodule

// File: rtl/mbx_duplex_chk.sv
// Module: mbx_duplex_chk
// Port-level temporal checks for mbx_duplex, attached by bind.
module mbx_duplex_chk #(
    parameter int HALF_W = 16,
    localparam int PAY_W = 2 * HALF_W - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic              host_rd,
    input logic [2:0]        host_addr,
    input logic [HALF_W-1:0] host_wdata,
    input logic              cp_in_valid,
    input logic [PAY_W-1:0]  cp_in_data,
    input logic              cp_in_take,
    input logic              cp_out_post,
    input logic              cp_out_ready
);
    // Checks the inbound flag and outbound ready after reset.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!cp_in_valid && cp_out_ready));

    // Checks that a high write delivers the flag and upper payload bits.
    assert_hi_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr[2:1] == 2'd0) |=>
        (cp_in_valid == $past(host_wdata[HALF_W-1]) &&
         cp_in_data[PAY_W-1:HALF_W] == $past(host_wdata[HALF_W-2:0])));

    // Checks that a take without a high write empties the inbound slot.
    assert_take_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_in_take && !(host_wr && host_addr[2:1] == 2'd0)) |=> !cp_in_valid);

    // Checks that an accepted post fills the outbound slot.
    assert_post_fills_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_out_post && cp_out_ready) |=> !cp_out_ready);

    // Checks that a low-half read of a full slot empties it.
    assert_read_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr[2:1] == 2'd3 && !cp_out_ready) |=> cp_out_ready);

    // Checks that host writes to the outbound offsets do not move the flag.
    assert_out_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_rd && host_addr[2] && !cp_out_post) |=> $stable(cp_out_ready));
endmodule

bind mbx_duplex mbx_duplex_chk #(.HALF_W(HALF_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .cp_in_valid (cp_in_valid),
    .cp_in_data  (cp_in_data),
    .cp_in_take  (cp_in_take),
    .cp_out_post (cp_out_post),
    .cp_out_ready(cp_out_ready)
);

// File: tb/mbx_duplex_tb_top.sv
// Directed bench for mbx_duplex: one task per scenario, each self-checking.
module mbx_duplex_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        cp_in_valid;
    logic [30:0] cp_in_data;
    logic        cp_in_take = 1'b0;
    logic        cp_out_post = 1'b0;
    logic [30:0] cp_out_post_data = '0;
    logic        cp_out_ready;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    mbx_duplex dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cp_in_valid(cp_in_valid), .cp_in_data(cp_in_data), .cp_in_take(cp_in_take),
        .cp_out_post(cp_out_post), .cp_out_post_data(cp_out_post_data),
        .cp_out_ready(cp_out_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Host write: one strobe cycle; returns at the following falling edge.
    task automatic host_write(input logic [2:0] a, input logic [15:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    // Host read: samples combinational data before the edge that acts.
    task automatic host_read(input logic [2:0] a, output logic [15:0] d);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic post(input logic [30:0] d);
        cp_out_post = 1'b1; cp_out_post_data = d;
        @(negedge clk);
        cp_out_post = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] r;
        for (int i = 0; i < 4; i++) begin
            host_read(3'(2 * i), r);
            chk("R1 read", {16'h0, r}, 32'h0);
        end
        chk("R1 in_valid", {31'h0, cp_in_valid}, 32'h0);
        chk("R1 out_ready", {31'h0, cp_out_ready}, 32'h1);
    endtask

    task automatic t_inbound();
        logic [15:0] r;
        host_write(3'h2, 16'hBEEF);
        chk("R2 valid unchanged", {31'h0, cp_in_valid}, 32'h0);
        host_read(3'h2, r);
        chk("R2 low readback", {16'h0, r}, 32'h0000BEEF);
        host_write(3'h0, 16'h8123);
        chk("R3 valid set", {31'h0, cp_in_valid}, 32'h1);
        chk("R3 payload", {1'b0, cp_in_data}, {1'b0, 15'h0123, 16'hBEEF});
        host_read(3'h0, r);
        chk("R3 high readback", {16'h0, r}, 32'h00008123);
        host_write(3'h2, 16'h1111);
        chk("R2 valid kept", {31'h0, cp_in_valid}, 32'h1);
        host_write(3'h0, 16'h0055);
        chk("R3 flag clear write", {31'h0, cp_in_valid}, 32'h0);
        chk("R3 payload 2", {1'b0, cp_in_data}, {1'b0, 15'h0055, 16'h1111});
    endtask

    task automatic t_take();
        logic [15:0] r;
        host_write(3'h0, 16'h8001);
        cp_in_take = 1'b1; @(negedge clk); cp_in_take = 1'b0;
        chk("R4 take clears", {31'h0, cp_in_valid}, 32'h0);
        chk("R4 data kept", {1'b0, cp_in_data}, {1'b0, 15'h0001, 16'h1111});
        host_read(3'h0, r);
        chk("R4 high readback", {16'h0, r}, 32'h00000001);
        cp_in_take = 1'b1; @(negedge clk); cp_in_take = 1'b0;
        host_read(3'h0, r);
        chk("R4 idle take", {16'h0, r}, 32'h00000001);
    endtask

    task automatic t_in_collide();
        host_write(3'h0, 16'h8AAA);
        cp_in_take = 1'b1;
        host_write(3'h0, 16'h8555);
        cp_in_take = 1'b0;
        chk("R5 write wins flag", {31'h0, cp_in_valid}, 32'h1);
        chk("R5 write wins data", {1'b0, cp_in_data}, {1'b0, 15'h0555, 16'h1111});
    endtask

    task automatic t_post();
        logic [15:0] r;
        post(31'h1234_5678);
        chk("R6 ready drops", {31'h0, cp_out_ready}, 32'h0);
        host_read(3'h4, r);
        chk("R6 out high", {16'h0, r}, {16'h0, 1'b1, 15'h1234});
        chk("R8 high read keeps flag", {31'h0, cp_out_ready}, 32'h0);
        host_read(3'h6, r);
        chk("R6 out low", {16'h0, r}, 32'h00005678);
        chk("R8 low read empties", {31'h0, cp_out_ready}, 32'h1);
        host_read(3'h4, r);
        chk("R8 flag bit clear", {16'h0, r}, 32'h00001234);
    endtask

    task automatic t_post_busy();
        logic [15:0] r;
        post(31'h2AAA_0101);
        post(31'h0555_0202);
        host_read(3'h4, r);
        chk("R7 busy post ignored hi", {16'h0, r}, {16'h0, 1'b1, 15'h2AAA});
        cp_out_post = 1'b1; cp_out_post_data = 31'h0777_0303;
        host_read(3'h6, r);
        cp_out_post = 1'b0;
        chk("R7 read old low", {16'h0, r}, 32'h00000101);
        chk("R8 empty after collide", {31'h0, cp_out_ready}, 32'h1);
        host_read(3'h4, r);
        chk("R7 collide post dropped", {16'h0, r}, 32'h00002AAA);
    endtask

    task automatic t_out_write();
        logic [15:0] r;
        post(31'h4321_9876);
        host_write(3'h4, 16'h0000);
        host_write(3'h6, 16'hFFFF);
        chk("R9 flag kept", {31'h0, cp_out_ready}, 32'h0);
        host_read(3'h4, r);
        chk("R9 high unchanged", {16'h0, r}, {16'h0, 1'b1, 15'h4321});
        host_read(3'h6, r);
        chk("R9 low unchanged", {16'h0, r}, 32'h00009876);
    endtask

    initial begin : watchdog
        #(20 * 200000);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_inbound();
        t_take();
        t_in_collide();
        t_post();
        t_post_busy();
        t_out_write();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule